// File: doc/BRIEF.md
# Spare-Port Remapper

This block sits between a switch core with M ports and a chip edge that has M+1 ports. One external position is left unused, so that a faulty link or neighbour can be routed around without changing how the core numbers its ports. Internal port i always lands on external position i or i+1. Every internal port is connected, the relative order of the internal ports never changes, and exactly one external position is isolated.

The block has two stream paths. The ingress path merges M+1 external valid/ready streams into the M core input streams. The egress path spreads the M core output streams across M+1 external streams, and each external output has its own drive enable. Both paths are purely combinational, so a transfer takes place in the cycle where valid and ready are both high. A ready signal never depends on the valid of the same stream. Back-pressure on a stream passes straight through to the stream it is mapped to. The isolated external input never shows ready, so a sender parked on that port stalls without losing data.

The isolation index is held in a small register and changes only on an explicit write. Two remappers can be chained by wiring external port M of one to external port 0 of the next. The index rules guarantee that at most one of the two drives that shared pin.

Top module: `spare_port_remap`

## Requirements
- R1: After reset the isolation index equals M (the top external position is isolated, giving an identity mapping) and the error flag is low.
- R2: A write with an index from 0 to M updates the isolation index on the next clock edge and clears the error flag.
- R3: A write with an index greater than M leaves the isolation index unchanged and sets the error flag. The flag stays set until the next legal write.
- R4: Without a write, the isolation index keeps its value.
- R5: Ingress: internal input i takes valid and data from external input i when i is below the isolation index, and from external input i+1 otherwise. There is no added latency.
- R6: The isolated external input is ignored. Its valid and data reach no internal port, and its ready is held low.
- R7: Ingress back-pressure: a non-isolated external input's ready equals the ready of the internal port it feeds.
- R8: Egress: external output j carries internal output j when j is below the isolation index, and internal output j-1 when j is above it.
- R9: Exactly one external output enable is low, at the isolation index. The isolated output shows valid 0 and data 0.
- R10: Egress back-pressure: internal output i's ready equals the ready of the external output it is mapped to (i or i+1, by the rule in R5).
- R11: Index 0 disables external port 0 and index M disables external port M, so two chained instances can share a boundary pin with only one driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Isolation index to write |
| cfg_iso | output | IW | Current isolation index |
| cfg_err | output | 1 | Illegal-index flag |
| ext_in_valid | input | M+1 | External input stream valids |
| ext_in_data | input | (M+1)*W | External input stream data, port j at bits j*W |
| ext_in_ready | output | M+1 | External input stream readies |
| int_in_valid | output | M | Core input valids |
| int_in_data | output | M*W | Core input data |
| int_in_ready | input | M | Core input readies |
| int_out_valid | input | M | Core output valids |
| int_out_data | input | M*W | Core output data |
| int_out_ready | output | M | Core output readies |
| ext_out_valid | output | M+1 | External output valids |
| ext_out_data | output | (M+1)*W | External output data |
| ext_out_en | output | M+1 | External output drive enables |
| ext_out_ready | input | M+1 | External output readies |

## Verification
The assertions assume that the configuration index is stable while the strobe is high. They also assume that stream inputs change only between clock edges, so any mapping check sampled after an edge sees settled values. The bench drives every input a moment after the rising edge and samples a half-cycle later. It holds the write strobe for exactly one cycle per reconfiguration. It walks the index through every legal value, including both boundary positions, and it tries out-of-range indices only as write values, never as the held state.

// File: rtl/spr_pkg.sv
`timescale 1ns/1ps
package spr_pkg;
  // True when a port position sits below the isolation index.
  function automatic logic pos_below(input int unsigned pos, input int unsigned iso);
    return pos < iso;
  endfunction
endpackage

// File: rtl/spr_cfg_reg.sv
`timescale 1ns/1ps
module spr_cfg_reg #(
  parameter int M  = 4,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  output logic [IW-1:0] iso_q,
  output logic          err_q
);
  localparam logic [IW-1:0] MAX_IDX = IW'(M);

  logic legal;
  assign legal = (idx <= MAX_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iso_q <= MAX_IDX;
      err_q <= 1'b0;
    end else if (we) begin
      if (legal) begin
        iso_q <= idx;
        err_q <= 1'b0;
      end else begin
        err_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spr_ingress.sv
`timescale 1ns/1ps
module spr_ingress #(
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [IW-1:0]      iso,
  input  logic [M:0]         ext_valid,
  input  logic [(M+1)*W-1:0] ext_data,
  output logic [M:0]         ext_ready,
  output logic [M-1:0]       int_valid,
  output logic [M*W-1:0]     int_data,
  input  logic [M-1:0]       int_ready
);
  import spr_pkg::*;

  // Core side: each internal port picks position i or i+1.
  for (genvar i = 0; i < M; i++) begin : g_core
    logic lo;
    assign lo = pos_below(i, int'(iso));
    assign int_valid[i]       = lo ? ext_valid[i]           : ext_valid[i+1];
    assign int_data[i*W +: W] = lo ? ext_data[i*W +: W]     : ext_data[(i+1)*W +: W];
  end

  // Edge side: ready follows the internal port the position feeds.
  for (genvar j = 0; j <= M; j++) begin : g_edge
    localparam logic [IW-1:0] JI = IW'(j);
    if (j == 0) begin : g_first
      assign ext_ready[j] = (iso == JI) ? 1'b0 : int_ready[0];
    end else if (j == M) begin : g_last
      assign ext_ready[j] = (iso == JI) ? 1'b0 : int_ready[M-1];
    end else begin : g_mid
      assign ext_ready[j] = (iso == JI) ? 1'b0 :
                            (JI < iso)  ? int_ready[j] : int_ready[j-1];
    end
  end
endmodule

// File: rtl/spr_egress.sv
`timescale 1ns/1ps
module spr_egress #(
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [IW-1:0]      iso,
  input  logic [M-1:0]       int_valid,
  input  logic [M*W-1:0]     int_data,
  output logic [M-1:0]       int_ready,
  output logic [M:0]         ext_valid,
  output logic [(M+1)*W-1:0] ext_data,
  output logic [M:0]         ext_en,
  input  logic [M:0]         ext_ready
);
  import spr_pkg::*;

  for (genvar i = 0; i < M; i++) begin : g_core
    assign int_ready[i] = pos_below(i, int'(iso)) ? ext_ready[i] : ext_ready[i+1];
  end

  for (genvar j = 0; j <= M; j++) begin : g_edge
    localparam logic [IW-1:0] JI = IW'(j);
    logic          hole;
    logic          v;
    logic [W-1:0]  d;
    assign hole = (iso == JI);
    if (j == 0) begin : g_first
      assign v = int_valid[0];
      assign d = int_data[0 +: W];
    end else if (j == M) begin : g_last
      assign v = int_valid[M-1];
      assign d = int_data[(M-1)*W +: W];
    end else begin : g_mid
      assign v = (JI < iso) ? int_valid[j]         : int_valid[j-1];
      assign d = (JI < iso) ? int_data[j*W +: W]   : int_data[(j-1)*W +: W];
    end
    assign ext_en[j]            = !hole;
    assign ext_valid[j]         = hole ? 1'b0 : v;
    assign ext_data[j*W +: W]   = hole ? '0   : d;
  end
endmodule

// File: rtl/spare_port_remap.sv
`timescale 1ns/1ps
module spare_port_remap #(
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int IW = $clog2(M + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IW-1:0]      cfg_idx,
  output logic [IW-1:0]      cfg_iso,
  output logic               cfg_err,
  input  logic [M:0]         ext_in_valid,
  input  logic [(M+1)*W-1:0] ext_in_data,
  output logic [M:0]         ext_in_ready,
  output logic [M-1:0]       int_in_valid,
  output logic [M*W-1:0]     int_in_data,
  input  logic [M-1:0]       int_in_ready,
  input  logic [M-1:0]       int_out_valid,
  input  logic [M*W-1:0]     int_out_data,
  output logic [M-1:0]       int_out_ready,
  output logic [M:0]         ext_out_valid,
  output logic [(M+1)*W-1:0] ext_out_data,
  output logic [M:0]         ext_out_en,
  input  logic [M:0]         ext_out_ready
);
  logic [IW-1:0] iso;

  spr_cfg_reg #(.M(M), .IW(IW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
    .iso_q(iso), .err_q(cfg_err)
  );

  assign cfg_iso = iso;

  spr_ingress #(.M(M), .W(W), .IW(IW)) u_in (
    .iso(iso),
    .ext_valid(ext_in_valid), .ext_data(ext_in_data), .ext_ready(ext_in_ready),
    .int_valid(int_in_valid), .int_data(int_in_data), .int_ready(int_in_ready)
  );

  spr_egress #(.M(M), .W(W), .IW(IW)) u_out (
    .iso(iso),
    .int_valid(int_out_valid), .int_data(int_out_data), .int_ready(int_out_ready),
    .ext_valid(ext_out_valid), .ext_data(ext_out_data), .ext_en(ext_out_en),
    .ext_ready(ext_out_ready)
  );
endmodule

// File: rtl/spr_chk.sv
`timescale 1ns/1ps
module spr_chk #(
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int IW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [IW-1:0]      cfg_idx,
  input logic [IW-1:0]      cfg_iso,
  input logic               cfg_err,
  input logic [M:0]         ext_in_valid,
  input logic [(M+1)*W-1:0] ext_in_data,
  input logic [M:0]         ext_in_ready,
  input logic [M-1:0]       int_in_valid,
  input logic [M*W-1:0]     int_in_data,
  input logic [M-1:0]       int_in_ready,
  input logic [M-1:0]       int_out_valid,
  input logic [M*W-1:0]     int_out_data,
  input logic [M-1:0]       int_out_ready,
  input logic [M:0]         ext_out_valid,
  input logic [(M+1)*W-1:0] ext_out_data,
  input logic [M:0]         ext_out_en,
  input logic [M:0]         ext_out_ready
);
  localparam logic [IW-1:0] MAX_IDX = IW'(M);

  // R2
  good_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx <= MAX_IDX) |=> (cfg_iso == $past(cfg_idx) && !cfg_err));

  // R3
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx > MAX_IDX) |=> (cfg_err && $stable(cfg_iso)));

  // R3
  iso_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_iso <= MAX_IDX);

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_iso));

  // R9
  one_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ext_out_en) == M) && !ext_out_en[cfg_iso]);

  // R9
  quiet_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_out_valid & ~ext_out_en) == '0);

  // R6
  hole_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_in_ready[cfg_iso]);

  // R5
  valid_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(int_in_valid) == ($countones(ext_in_valid) - 32'(ext_in_valid[cfg_iso])));
endmodule

bind spare_port_remap spr_chk #(.M(M), .W(W), .IW(IW)) u_chk (.*);

// File: tb/spare_port_remap_bench.sv
`timescale 1ns/1ps
module spare_port_remap_bench;
  localparam int M  = 4;
  localparam int W  = 8;
  localparam int IW = $clog2(M + 2);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_we = 1'b0;
  logic [IW-1:0]      cfg_idx = '0;
  logic [IW-1:0]      cfg_iso;
  logic               cfg_err;
  logic [M:0]         ext_in_valid = '0;
  logic [(M+1)*W-1:0] ext_in_data = '0;
  logic [M:0]         ext_in_ready;
  logic [M-1:0]       int_in_valid;
  logic [M*W-1:0]     int_in_data;
  logic [M-1:0]       int_in_ready = '0;
  logic [M-1:0]       int_out_valid = '0;
  logic [M*W-1:0]     int_out_data = '0;
  logic [M-1:0]       int_out_ready;
  logic [M:0]         ext_out_valid;
  logic [(M+1)*W-1:0] ext_out_data;
  logic [M:0]         ext_out_en;
  logic [M:0]         ext_out_ready = '0;

  always #10 clk = ~clk; // 50 MHz

  spare_port_remap #(.M(M), .W(W)) u_spare_port_remap (.*);

  typedef struct {
    logic [M-1:0]       ivld;
    logic [M*W-1:0]     idat;
    logic [M:0]         erdy;
    logic [M:0]         evld;
    logic [(M+1)*W-1:0] edat;
    logic [M:0]         een;
    logic [M-1:0]       irdy;
    logic [IW-1:0]      iso;
    logic               err;
    string              note;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  logic [IW-1:0] m_iso = IW'(M);
  logic          m_err = 1'b0;
  bit done = 0;

  task automatic chk(string tag, logic ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Expected model from the mapping rules (R5, R7, R8, R9, R10)
  function automatic exp_t model(string note);
    exp_t e;
    int s, k;
    e.note = note; e.iso = m_iso; e.err = m_err;
    e.ivld = '0; e.idat = '0; e.irdy = '0;
    e.erdy = '0; e.evld = '0; e.edat = '0; e.een = '0;
    for (int i = 0; i < M; i++) begin
      s = (i < int'(m_iso)) ? i : i + 1;
      e.ivld[i] = ext_in_valid[s];
      e.idat[i*W +: W] = ext_in_data[s*W +: W];
      e.irdy[i] = ext_out_ready[s];
    end
    for (int j = 0; j <= M; j++) begin
      if (j != int'(m_iso)) begin
        k = (j < int'(m_iso)) ? j : j - 1;
        e.erdy[j] = int_in_ready[k];
        e.evld[j] = int_out_valid[k];
        e.edat[j*W +: W] = int_out_data[k*W +: W];
        e.een[j] = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic drive_random(string note);
    @(posedge clk); #1;
    ext_in_valid  = ($urandom() % 32) | 1;
    ext_in_data   = {$urandom(), $urandom()};
    int_in_ready  = $urandom();
    int_out_valid = $urandom();
    int_out_data  = $urandom();
    ext_out_ready = $urandom();
    q.push_back(model(note));
  endtask

  // Only the isolated input is active (R6)
  task automatic drive_hole_only();
    @(posedge clk); #1;
    ext_in_valid = '0;
    ext_in_valid[m_iso] = 1'b1;
    ext_in_data  = '0;
    ext_in_data[m_iso*W +: W] = 8'hA5;
    int_in_ready = '1;
    q.push_back(model("R6"));
  endtask

  task automatic write_cfg(int idx);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = IW'(idx);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (idx <= M) begin m_iso = IW'(idx); m_err = 1'b0; end
    else m_err = 1'b1;
  endtask

  // Monitor: pops each expected item half a cycle after it was driven
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.note, " R2 R3 R4 iso"}, cfg_iso == e.iso, 64'(cfg_iso), 64'(e.iso));
        chk({e.note, " R3 err"}, cfg_err == e.err, 64'(cfg_err), 64'(e.err));
        chk({e.note, " R5 R6 int_in_valid"}, int_in_valid == e.ivld, 64'(int_in_valid), 64'(e.ivld));
        chk({e.note, " R5 R6 int_in_data"}, int_in_data == e.idat, 64'(int_in_data), 64'(e.idat));
        chk({e.note, " R6 R7 ext_in_ready"}, ext_in_ready == e.erdy, 64'(ext_in_ready), 64'(e.erdy));
        chk({e.note, " R8 ext_out_valid"}, ext_out_valid == e.evld, 64'(ext_out_valid), 64'(e.evld));
        chk({e.note, " R8 ext_out_data"}, ext_out_data == e.edat, 64'(ext_out_data), 64'(e.edat));
        chk({e.note, " R9 R11 ext_out_en"}, ext_out_en == e.een, 64'(ext_out_en), 64'(e.een));
        chk({e.note, " R10 int_out_ready"}, int_out_ready == e.irdy, 64'(int_out_ready), 64'(e.irdy));
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 iso after reset", cfg_iso == IW'(M), 64'(cfg_iso), 64'(M));
    chk("R1 err after reset", cfg_err == 1'b0, 64'(cfg_err), 64'd0);
    chk("R1 enables after reset", ext_out_en == {1'b0, {M{1'b1}}}, 64'(ext_out_en), 64'({1'b0, {M{1'b1}}}));

    for (int r = 0; r < 3; r++) drive_random("R11 top");
    drive_hole_only();

    write_cfg(0);
    for (int r = 0; r < 3; r++) drive_random("R11 bottom");
    drive_hole_only();

    write_cfg(2);
    for (int r = 0; r < 3; r++) drive_random("mid");
    drive_hole_only();

    write_cfg(5);   // illegal
    for (int r = 0; r < 2; r++) drive_random("illegal5");
    write_cfg(7);   // illegal
    for (int r = 0; r < 2; r++) drive_random("illegal7");

    write_cfg(1);   // legal, clears err
    for (int r = 0; r < 3; r++) drive_random("clear");
    drive_hole_only();

    write_cfg(3);
    for (int r = 0; r < 3; r++) drive_random("idx3");
    drive_hole_only();

    write_cfg(4);
    for (int r = 0; r < 2; r++) drive_random("R11 back");

    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule